// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor and a slower, word-addressed main memory. It keeps one line per index. Each line holds a valid flag, a stored tag and a block of several words, so a refill also brings in the neighbours of the requested word. The processor presents a byte address, a read/write flag and write data. It receives read data, a hit flag and a stall flag, and it must hold its request steady for as long as stall is high. On the memory side the controller raises a request with a word address and waits for a one-cycle acknowledge for each word it moves.

Every write goes to memory, whether it hits or misses. A write also updates the cached copy, so the line never holds data that memory lacks. On a miss of either kind, the controller first fetches the whole block into the line and then replays the access as a hit. The default configuration has 16 lines of four 32-bit words. The index width is a parameter, so the wide 12-bit-index layout is also available.

The controller is a three-state machine:

- **ST_COMPARE** looks up the presented address.
  - A miss takes transition *miss → ST_REFILL*.
  - A write hit takes transition *write-hit → ST_WRITE_MEM*.
  - A read hit stays in ST_COMPARE.
- **ST_REFILL** walks a word counter through the block.
  - It takes transition *last-word-ack → ST_COMPARE*, which replays the access.
- **ST_WRITE_MEM** holds the single word write.
  - It takes transition *write-ack → ST_COMPARE*.

Top module: `wt_cache_ctrl`

## Requirements
- R1: The byte address splits as follows, from bit 0 upward: the byte offset (BYTE_W bits, 2 by default), the word-in-block offset (BLK_W bits, 2), the line index (IDX_W bits, 4), and the tag (the remaining upper bits). The word offset selects which word of the line a read hit returns.
- R2: After reset every line is invalid. With no request the outputs are cpu_stall=0 and mem_req=0, and the first access to any line misses.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. A read hit returns the word in the same cycle as the request, with cpu_hit=1 and cpu_stall=0, and it makes no memory request.
- R4: On a read miss cpu_stall stays high while all words of the block are read from memory. The reads go in word-offset order 0, 1, 2, 3 at word address {tag, index, offset}, one read per acknowledge. The access then completes as a hit that returns the fetched word.
- R5: A write hit updates the cached word and issues exactly one memory write of that word at word address {tag, index, offset}, with no memory reads. cpu_stall is high until the acknowledge cycle and low in that cycle. Later reads return the new data.
- R6: A write miss first refills the whole block in order from memory and then performs the write as in R5. The other words of the line come from memory, and the addressed word holds the new data.
- R7: Two addresses with the same index and different tags evict each other. Alternating accesses between them miss every time, and each miss reads a full block.
- R8: Once mem_req is raised, mem_req, mem_we and mem_addr stay unchanged until the cycle in which mem_ack is seen.
- R9: The byte-offset bits have no effect: addresses that differ only there hit the same word and return the same data.
- R10: Refilling one line leaves every other line's contents and validity untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid on a read hit |
| cpu_hit | output | 1 | Lookup hit in the comparing state |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W-BYTE_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge for the current word |

## Verification
The checks concentrate on faults in the internal state.

- A valid flag that survives reset, or a tag that is not updated on refill, turns a miss into a hit. This shows up in the first cycle of the access as cpu_hit=1, cpu_stall=0 and no memory reads.
- A word counter that skips or repeats shows up within a few cycles as an out-of-order word address on the memory side. It also shows up later as wrong data on a read hit.
- A cached write that is lost or sent to the wrong place shows only when the line is read again. This is why the conflict sequence re-reads a written word after its line has been evicted.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_COMPARE   = 2'd0,
        ST_REFILL    = 2'd1,
        ST_WRITE_MEM = 2'd2
    } wtc_state_t;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] line_ok;
    logic [TAG_W-1:0] tag_mem [LINES];

    // valid flags are the only reset state (R2)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_ok <= '0;
        end else if (fill_en) begin
            line_ok[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[fill_idx] <= fill_tag;
        end
    end

    assign lk_hit = line_ok[lk_idx] && (tag_mem[lk_idx] == lk_tag);

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (line_ok[$past(fill_idx)] && tag_mem[$past(fill_idx)] == $past(fill_tag))); // R4
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
    parameter int IDX_W  = 4,
    parameter int BLK_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [BLK_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BLK_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int ENTRIES = 1 << (IDX_W + BLK_W);

    logic [DATA_W-1:0] words [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[{wr_idx, wr_off}] <= wr_data;
        end
    end

    assign rd_data = words[{rd_idx, rd_off}];
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int BLK_W  = 2,
    parameter int BYTE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_hit,
    output logic                     cpu_stall,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-BYTE_W-1:0] mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic                     mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W - BLK_W - BYTE_W;
    localparam logic [BLK_W-1:0] LAST_OFF = '1;
    localparam logic [BLK_W-1:0] ONE_OFF  = BLK_W'(1);

    // address fields (R1); byte offset deliberately unused (R9)
    logic [BLK_W-1:0] a_off;
    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    logic             byte_unused;
    assign a_off       = cpu_addr[BYTE_W +: BLK_W];
    assign a_idx       = cpu_addr[BYTE_W + BLK_W +: IDX_W];
    assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign byte_unused = ^cpu_addr[BYTE_W-1:0];

    wtc_state_t        state, nxt;
    logic [TAG_W-1:0]  l_tag;
    logic [IDX_W-1:0]  l_idx;
    logic [BLK_W-1:0]  l_off;
    logic [DATA_W-1:0] l_data;
    logic [BLK_W-1:0]  word_cnt;
    logic              capture;

    logic              lk_hit, fill_en;
    logic              dwr_en;
    logic [IDX_W-1:0]  dwr_idx;
    logic [BLK_W-1:0]  dwr_off;
    logic [DATA_W-1:0] dwr_data;

    wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (a_idx),
        .lk_tag   (a_tag),
        .lk_hit   (lk_hit),
        .fill_en  (fill_en),
        .fill_idx (l_idx),
        .fill_tag (l_tag)
    );

    wtc_data_store #(.IDX_W(IDX_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (a_idx),
        .rd_off  (a_off),
        .rd_data (cpu_rdata),
        .wr_en   (dwr_en),
        .wr_idx  (dwr_idx),
        .wr_off  (dwr_off),
        .wr_data (dwr_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COMPARE;
        end else begin
            state <= nxt;
        end
    end

    // request capture and refill word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_cnt <= '0;
            l_tag    <= '0;
            l_idx    <= '0;
            l_off    <= '0;
            l_data   <= '0;
        end else if (capture) begin
            word_cnt <= '0;
            l_tag    <= a_tag;
            l_idx    <= a_idx;
            l_off    <= a_off;
            l_data   <= cpu_wdata;
        end else if (state == ST_REFILL && mem_ack) begin
            word_cnt <= word_cnt + ONE_OFF;
        end
    end

    // outputs and next state
    always_comb begin
        nxt       = state;
        cpu_hit   = 1'b0;
        cpu_stall = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {l_tag, l_idx, l_off};
        mem_wdata = l_data;
        capture   = 1'b0;
        fill_en   = 1'b0;
        dwr_en    = 1'b0;
        dwr_idx   = a_idx;
        dwr_off   = a_off;
        dwr_data  = cpu_wdata;
        unique case (state)
            ST_COMPARE: begin
                if (cpu_req) begin
                    cpu_hit = lk_hit;
                    if (!lk_hit) begin
                        cpu_stall = 1'b1;
                        capture   = 1'b1;
                        nxt       = ST_REFILL;
                    end else if (cpu_we) begin
                        cpu_stall = 1'b1;
                        capture   = 1'b1;
                        dwr_en    = 1'b1;
                        nxt       = ST_WRITE_MEM;
                    end
                end
            end
            ST_REFILL: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                mem_addr  = {l_tag, l_idx, word_cnt};
                dwr_idx   = l_idx;
                dwr_off   = word_cnt;
                dwr_data  = mem_rdata;
                if (mem_ack) begin
                    dwr_en = 1'b1;
                    if (word_cnt == LAST_OFF) begin
                        fill_en = 1'b1;
                        nxt     = ST_COMPARE;
                    end
                end
            end
            ST_WRITE_MEM: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                cpu_stall = !mem_ack;
                if (mem_ack) begin
                    nxt = ST_COMPARE;
                end
            end
            default: nxt = ST_COMPARE;
        endcase
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8
    AST_READ_DONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_stall) |-> (cpu_hit && !mem_req)); // R3
    AST_WRITE_DONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_stall) |-> (mem_req && mem_we && mem_ack)); // R5
    AST_REFILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && mem_addr[BLK_W-1:0] != LAST_OFF)
        |=> (mem_req && !mem_we && mem_addr[BLK_W-1:0] == $past(mem_addr[BLK_W-1:0]) + ONE_OFF)); // R4
endmodule

// File: tb/wt_cache_ctrl_test.sv
module wt_cache_ctrl_test;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_hit, cpu_stall;
    logic        mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #4 clk = ~clk;

    wt_cache_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int          n_tests = 0, n_fail = 0;
    int          wr_cnt = 0, hold_err = 0, wait_c = 0;
    logic [29:0] rd_log [$];
    logic [29:0] last_wr_a, pend_a;
    logic [31:0] last_wr_d;
    logic        pend_we;
    logic [31:0] wmem [logic [29:0]];

    function automatic logic [31:0] model(input logic [29:0] wa);
        if (wmem.exists(wa)) return wmem[wa];
        return ({2'b00, wa} * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction

    function automatic logic [29:0] wa(input logic [23:0] t, input logic [3:0] i, input logic [1:0] o);
        return {t, i, o};
    endfunction

    // memory responder: acknowledges after LAT waiting cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wait_c  = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_c == 0) begin
                pend_a  = mem_addr;
                pend_we = mem_we;
            end else if (mem_addr !== pend_a || mem_we !== pend_we) begin
                hold_err++;
            end
            if (wait_c == LAT) begin
                mem_ack = 1'b1;
                wait_c  = 0;
                if (mem_we) begin
                    wmem[mem_addr] = mem_wdata;
                    wr_cnt++;
                    last_wr_a = mem_addr;
                    last_wr_d = mem_wdata;
                end else begin
                    mem_rdata = model(mem_addr);
                    rd_log.push_back(mem_addr);
                end
            end else begin
                wait_c++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output bit first_hit, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cyc = 0; rd = '0; first_hit = 1'b0;
        forever begin
            #3;
            if (cyc == 0) first_hit = cpu_hit;
            cyc++;
            if (!cpu_stall) begin
                rd = cpu_rdata;
                break;
            end
            if (cyc > 200) break;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    function automatic logic [31:0] ba(input logic [29:0] w, input logic [1:0] b);
        return {w, b};
    endfunction

    localparam logic [23:0] TA = 24'h0000A1, TB = 24'h0000B2, TC = 24'h0000C7;
    localparam logic [31:0] D1 = 32'hDEAD_0001, D2 = 32'hBEEF_0002;

    task automatic t_reset();
        #3;
        chk(cpu_stall == 1'b0, "R2", "idle stall after reset", {31'd0, cpu_stall}, 32'd0);
        chk(mem_req == 1'b0, "R2", "idle mem_req after reset", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_cold_read();
        logic [31:0] rd; bit h; int c;
        rd_log.delete();
        access(1'b0, ba(wa(TA, 4'd3, 2'd2), 2'd0), '0, rd, h, c);
        chk(!h, "R2", "first access misses", {31'd0, h}, 32'd0);
        chk(rd_log.size() == 4, "R4", "refill read count", rd_log.size(), 32'd4);
        for (int k = 0; k < 4; k++)
            if (rd_log.size() > k)
                chk(rd_log[k] == wa(TA, 4'd3, 2'(k)), "R4", "refill order",
                    {2'b0, rd_log[k]}, {2'b0, wa(TA, 4'd3, 2'(k))});
        chk(rd == model(wa(TA, 4'd3, 2'd2)), "R4", "miss data", rd, model(wa(TA, 4'd3, 2'd2)));
    endtask

    task automatic t_read_hit();
        logic [31:0] rd; bit h; int c;
        rd_log.delete();
        access(1'b0, ba(wa(TA, 4'd3, 2'd1), 2'd0), '0, rd, h, c);
        chk(h && c == 1, "R3", "read hit same cycle", c, 32'd1);
        chk(rd == model(wa(TA, 4'd3, 2'd1)), "R3", "hit data", rd, model(wa(TA, 4'd3, 2'd1)));
        access(1'b0, ba(wa(TA, 4'd3, 2'd1), 2'd3), '0, rd, h, c);
        chk(h && rd == model(wa(TA, 4'd3, 2'd1)), "R9", "byte offset ignored", rd, model(wa(TA, 4'd3, 2'd1)));
        access(1'b0, ba(wa(TA, 4'd3, 2'd3), 2'd0), '0, rd, h, c);
        chk(h && rd == model(wa(TA, 4'd3, 2'd3)), "R1", "word offset select", rd, model(wa(TA, 4'd3, 2'd3)));
        chk(rd_log.size() == 0, "R3", "no memory reads on hits", rd_log.size(), 32'd0);
    endtask

    task automatic t_write_hit();
        logic [31:0] rd; bit h; int c; int w0;
        rd_log.delete(); w0 = wr_cnt;
        access(1'b1, ba(wa(TA, 4'd3, 2'd0), 2'd0), D1, rd, h, c);
        chk(h, "R5", "write hit flag", {31'd0, h}, 32'd1);
        chk(rd_log.size() == 0, "R5", "write hit no reads", rd_log.size(), 32'd0);
        chk(wr_cnt == w0 + 1, "R5", "one memory write", wr_cnt - w0, 32'd1);
        chk(last_wr_a == wa(TA, 4'd3, 2'd0) && last_wr_d == D1, "R5", "write addr/data",
            last_wr_d, D1);
        chk(c == LAT + 2, "R5", "stalled until ack", c, LAT + 2);
        access(1'b0, ba(wa(TA, 4'd3, 2'd0), 2'd0), '0, rd, h, c);
        chk(h && rd == D1, "R5", "cached new data", rd, D1);
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; bit h; int c; int w0;
        rd_log.delete(); w0 = wr_cnt;
        access(1'b1, ba(wa(TB, 4'd5, 2'd3), 2'd0), D2, rd, h, c);
        chk(!h, "R6", "write miss flag", {31'd0, h}, 32'd0);
        chk(rd_log.size() == 4, "R6", "block refilled first", rd_log.size(), 32'd4);
        if (rd_log.size() == 4)
            chk(rd_log[0] == wa(TB, 4'd5, 2'd0) && rd_log[3] == wa(TB, 4'd5, 2'd3), "R6",
                "refill addresses", {2'b0, rd_log[3]}, {2'b0, wa(TB, 4'd5, 2'd3)});
        chk(wr_cnt == w0 + 1 && last_wr_a == wa(TB, 4'd5, 2'd3) && last_wr_d == D2, "R6",
            "memory write after refill", last_wr_d, D2);
        access(1'b0, ba(wa(TB, 4'd5, 2'd3), 2'd0), '0, rd, h, c);
        chk(h && rd == D2, "R6", "written word cached", rd, D2);
        access(1'b0, ba(wa(TB, 4'd5, 2'd0), 2'd0), '0, rd, h, c);
        chk(h && rd == model(wa(TB, 4'd5, 2'd0)), "R6", "neighbour from memory", rd,
            model(wa(TB, 4'd5, 2'd0)));
    endtask

    task automatic t_conflict();
        logic [31:0] rd; bit h; int c;
        for (int r = 0; r < 3; r++) begin
            logic [23:0] t;
            t = (r == 1) ? TA : TC;
            rd_log.delete();
            access(1'b0, ba(wa(t, 4'd3, 2'd0), 2'd0), '0, rd, h, c);
            chk(!h && rd_log.size() == 4, "R7", "conflict miss", rd_log.size(), 32'd4);
            chk(rd == model(wa(t, 4'd3, 2'd0)), "R7", "conflict data", rd, model(wa(t, 4'd3, 2'd0)));
        end
        chk(model(wa(TA, 4'd3, 2'd0)) == D1, "R5", "write reached memory", model(wa(TA, 4'd3, 2'd0)), D1);
    endtask

    task automatic t_independent();
        logic [31:0] rd; bit h; int c;
        rd_log.delete();
        access(1'b0, ba(wa(TB, 4'd5, 2'd3), 2'd2), '0, rd, h, c);
        chk(h && rd == D2 && rd_log.size() == 0, "R10", "other line untouched", rd, D2);
        chk(hold_err == 0, "R8", "request held until ack", hold_err, 32'd0);
    endtask

    initial begin
        #(8 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_read();
        t_read_hit();
        t_write_hit();
        t_write_miss();
        t_conflict();
        t_independent();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule